// File: doc/BRIEF.md
# SMBus Stalled-Bus Watchdog

This block sits next to an SMBus slave and watches the slave's already-synchronized clock and data lines. If a line it has been told to watch stays low for too long, the watchdog emits a one-cycle `bus_reset` pulse. That pulse sends the slave's state machine back to idle, so the slave lets go of SDA and a hung transfer cannot hold the bus forever.

Detection on each line is switched on separately by two bits of an 8-bit configuration register. The register clears to zero on reset, so both detections start off. The timeout length is a parameter counted in system-clock cycles. Its default is 3,125,000 cycles, which is 25 ms at 125 MHz. Each line has its own counter, and a counter that has already fired stays quiet until its line has been seen high again.

Top module: `smbus_idle_watchdog`

## Requirements
- R1: After a synchronous reset the configuration register reads 0x00, so both detections are off and `bus_reset` is low.
- R2: A cycle with `cfg_wr_en` high loads all eight bits of `cfg_wr_data`. The new value appears on `cfg_rd_data` after that edge, and the register keeps its value when no write occurs.
- R3: Bit 5 of the configuration register enables SDA stall detection and bit 4 enables SCL stall detection. The other six bits are stored but have no effect on `bus_reset`.
- R4: For an enabled line, call a sample "stalled" when the line is low at a rising edge and was also low at the previous edge. On the TIMEOUT_CYCLES-th consecutive stalled sample (the line low at TIMEOUT_CYCLES+1 edges in a row), `bus_reset` goes high for the next cycle.
- R5: Any high sample, or the falling edge into a low level, restarts that line's count. A low stretch of TIMEOUT_CYCLES edges or fewer never produces a pulse.
- R6: Each pulse lasts exactly one cycle. A line that has fired does not fire again, however long it stays low, until it has been sampled high.
- R7: A line whose enable bit is 0 never causes a pulse. Clearing the bit during a low stretch discards that line's count, and counting restarts from zero if the bit is set again.
- R8: The two lines are timed independently and either one can cause a pulse. If both expire on the same edge, a single pulse results.
- R9: Asserting `rst` in the middle of a low stretch clears both counts and the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration register |
| cfg_wr_data | input | 8 | Value to load into the configuration register |
| cfg_rd_data | output | 8 | Current value of the configuration register |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| bus_reset | output | 1 | One-cycle pulse that returns the slave to idle |

## Verification
The bench targets the exact edge on which the pulse appears. A count that is off by one would fire a cycle early or late. It would also fire on a low stretch exactly TIMEOUT_CYCLES edges long, which must stay silent.

Several cases check that the watchdog does not fire when it should not:
- A long stall must give one pulse and no more. A missing re-arm rule would give repeated pulses.
- Writing every configuration bit except bits 5 and 4 must give no pulse. A wrong bit position would fire here.
- Disabling a line mid-stall, or resetting mid-stall, must discard the count. A design that kept the count would fire early after re-enable.

Stalls on the two lines are also run both at the same time and a few cycles apart. A merged or shared counter would drop a pulse or give the wrong number of pulses.

// File: rtl/smbus_wdt_pkg.sv
package smbus_wdt_pkg;
  // Enable bit positions inside the configuration byte; line index 0 is SCL, 1 is SDA
  localparam int SCL_EN_BIT = 4;
  localparam int SDA_EN_BIT = 5;
  localparam int NUM_LINES  = 2;
  localparam logic [7:0] CFG_RESET_VALUE = 8'h00;
endpackage

// File: rtl/swdt_cfg_reg.sv
module swdt_cfg_reg #(
  parameter int         WIDTH     = 8,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RESET_VAL[WIDTH-1:0];
    else if (wr_en) q <= wr_data;
  end

  // R2: without a write the stored byte does not change
  p_hold_value_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> $stable(q));
endmodule

// File: rtl/swdt_stall_timer.sv
module swdt_stall_timer #(
  parameter int TIMEOUT_CYCLES = 3_125_000,
  localparam int CW = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic line,
  output logic hit
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic          line_q;
  logic [CW-1:0] cnt;
  logic          expired;
  logic          stalled;

  always_comb begin
    stalled = en && !line && !line_q;
    hit     = stalled && !expired && (cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= 1'b1;
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      line_q <= line;
      if (!stalled) begin
        cnt     <= '0;
        expired <= 1'b0;
      end else if (hit) begin
        expired <= 1'b1;
      end else if (!expired) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: the timer never fires on two consecutive edges
  p_single_fire_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
  // R4: the count never runs past the terminal value
  p_count_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/smbus_idle_watchdog.sv
module smbus_idle_watchdog
  import smbus_wdt_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 3_125_000,
  parameter int CFG_W          = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             bus_reset
);
  logic [CFG_W-1:0]     cfg_q;
  logic [NUM_LINES-1:0] lines;
  logic [NUM_LINES-1:0] hits;

  swdt_cfg_reg #(.WIDTH(CFG_W), .RESET_VAL(CFG_RESET_VALUE)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .q(cfg_q)
  );

  assign lines       = {sda_in, scl_in};
  assign cfg_rd_data = cfg_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    swdt_stall_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
      .clk (clk),
      .rst (rst),
      .en  (cfg_q[SCL_EN_BIT + i]),
      .line(lines[i]),
      .hit (hits[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bus_reset <= 1'b0;
    else     bus_reset <= |hits;
  end

  // R7: a pulse needs at least one enable bit set on the deciding edge
  p_pulse_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> ($past(cfg_q[SDA_EN_BIT]) || $past(cfg_q[SCL_EN_BIT])));
  // R4: a pulse needs a low line on the deciding edge
  p_pulse_needs_low_r4: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> ($past(!sda_in) || $past(!scl_in)));
endmodule

// File: tb/smbus_idle_watchdog_tb.sv
module smbus_idle_watchdog_tb;
  localparam int T = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       bus_reset;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  logic [7:0] m_cfg = 8'h00;
  int  m_run[2]  = '{0, 0};
  bit  m_done[2] = '{0, 0};
  bit  m_prev[2] = '{1, 1};
  bit  m_out = 0;

  always #4 clk = ~clk;

  smbus_idle_watchdog #(.TIMEOUT_CYCLES(T)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .scl_in(scl_in), .sda_in(sda_in), .bus_reset(bus_reset)
  );

  task automatic model_edge();
    bit fire = 0;
    if (rst) begin
      m_cfg = 8'h00; m_out = 0;
      for (int i = 0; i < 2; i++) begin m_run[i] = 0; m_done[i] = 0; m_prev[i] = 1; end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit en = (i == 1) ? m_cfg[5] : m_cfg[4];
        bit ln = (i == 1) ? sda_in : scl_in;
        if (!en || ln || m_prev[i]) begin
          m_run[i] = 0; m_done[i] = 0;
        end else if (!m_done[i]) begin
          if (m_run[i] == T - 1) begin fire = 1; m_done[i] = 1; end
          else m_run[i]++;
        end
        m_prev[i] = ln;
      end
      m_out = fire;
      if (cfg_wr_en) m_cfg = cfg_wr_data;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    #2;
    if (bus_reset === 1'b1) pulses++;
    check(tag, "bus_reset", int'(bus_reset), int'(m_out));
    check(tag, "cfg_rd_data", int'(cfg_rd_data), int'(m_cfg));
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic write_cfg(logic [7:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    cycle();
    cfg_wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    sda_in = 1'b1; scl_in = 1'b1;
    run(n);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    run(3);
    rst = 1'b0;
    cycle();
    check("R1", "cfg after reset", int'(cfg_rd_data), 0);
    check("R1", "bus_reset after reset", int'(bus_reset), 0);

    // R7: both lines low, both disabled
    tag = "R7"; pulses = 0;
    sda_in = 1'b0; scl_in = 1'b0; run(50);
    check("R7", "pulses while disabled", pulses, 0);
    idle(4);

    // R2 + R3 + R4: SDA only enabled, both lines low, one pulse
    tag = "R2"; write_cfg(8'h20);
    check("R2", "cfg readback", int'(cfg_rd_data), 32'h20);
    tag = "R4"; pulses = 0;
    sda_in = 1'b0; scl_in = 1'b0; run(30);
    check("R4", "pulses on SDA stall", pulses, 1);
    idle(4);

    // R4 boundary: exactly T low samples must not fire
    tag = "R4"; pulses = 0;
    sda_in = 1'b0; run(T); sda_in = 1'b1; run(3);
    check("R4", "pulses on T-edge stretch", pulses, 0);

    // R5: repeated short lows with one high sample between
    tag = "R5"; pulses = 0;
    for (int r = 0; r < 4; r++) begin
      sda_in = 1'b0; run(15); sda_in = 1'b1; run(1);
    end
    check("R5", "pulses on short lows", pulses, 0);
    idle(3);

    // R3: SCL only
    tag = "R3"; write_cfg(8'h10); pulses = 0;
    sda_in = 1'b0; scl_in = 1'b0; run(30);
    check("R3", "pulses on SCL stall", pulses, 1);
    idle(3);

    // R3: every other bit set, no effect
    tag = "R3"; write_cfg(8'hCF); pulses = 0;
    sda_in = 1'b0; scl_in = 1'b0; run(40);
    check("R3", "pulses with non-enable bits", pulses, 0);
    idle(3);

    // R8: both enabled, simultaneous stall gives one pulse
    tag = "R8"; write_cfg(8'h30); pulses = 0;
    sda_in = 1'b0; scl_in = 1'b0; run(30);
    check("R8", "pulses on joint stall", pulses, 1);
    idle(3);

    // R8: staggered stalls give two pulses
    tag = "R8"; pulses = 0;
    sda_in = 1'b0; run(3); scl_in = 1'b0; run(30);
    check("R8", "pulses on staggered stall", pulses, 2);
    idle(3);

    // R7: disabling mid-stall drops the count
    tag = "R7"; pulses = 0;
    sda_in = 1'b0; run(15);
    write_cfg(8'h10); run(4);
    write_cfg(8'h30); run(15);
    check("R7", "pulses after disable mid-stall", pulses, 0);
    idle(3);

    // R9: reset mid-stall clears counts and register
    tag = "R9"; pulses = 0;
    sda_in = 1'b0; run(15);
    rst = 1'b1; run(2); rst = 1'b0;
    check("R9", "cfg after mid reset", int'(cfg_rd_data), 0);
    write_cfg(8'h30); run(15);
    check("R9", "pulses after mid reset", pulses, 0);
    idle(3);

    // R6: long stall fires once, re-arms after a high sample
    tag = "R6"; write_cfg(8'h20); pulses = 0;
    sda_in = 1'b0; run(70);
    check("R6", "pulses on long stall", pulses, 1);
    sda_in = 1'b1; run(1); sda_in = 1'b0; run(25);
    check("R6", "pulses after re-arm", pulses, 2);
    idle(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule